// File: doc/BRIEF.md
# Uplink Frame Receiver with NRZI Decoding and Link-Layer Validation

This block sits behind a roadside transceiver's demodulator and turns the raw uplink sample stream from a vehicle transponder into checked frames. Each sample arrives as a data level with a one-cycle strobe. The block NRZI-decodes the samples and waits for a run of synchronising zeros. It then locks onto the opening flag, strips stuffed zeros and packs the remaining bits into octets, least significant bit first. It also runs a CRC over everything between the flags.

While octets arrive, the block splits off the variable-length link address and the MAC control octet. It streams the remaining octets out as payload and holds back the last two, which are the frame check sequence. At the closing flag it applies every acceptance rule and reports the frame with a single pulse: accepted or rejected. A run of seven ones inside a frame cancels it at once and produces a rejection pulse. After each frame, whether it ends or is cancelled, the block looks for a fresh preamble.

Top module: `uplink_deframer`

## Requirements
- R1: A sample that equals the previous sample decodes as 1, and a change of level decodes as 0. The level before the first sample is taken as high. A frame is searched for only after 8 consecutive decoded zeros; a frame without that run produces neither a pulse nor payload.
- R2: The pattern 0,1,1,1,1,1,1,0 opens and closes a frame. Octets between the flags are sent least significant bit first. A frame that meets every rule gives exactly one frame_ok pulse.
- R3: A decoded 0 that follows five consecutive data ones is removed, and is not counted as data.
- R4: Seven consecutive ones inside a frame cancel it: one frame_err pulse, and no frame_ok.
- R5: If the destuffed bit count between the flags is not a multiple of 8, the frame is rejected.
- R6: If there are more than MAX_OCT octets between the flags (address, control, payload and check octets together), the frame is rejected.
- R7: The check field is two octets, low octet first, holding the ones' complement of a reflected CRC-16 (polynomial x^16+x^12+x^5+1, preset 0xFFFF). A mismatch rejects the frame.
- R8: The address runs up to and including the first octet whose bit 0 is 1, and may be 1 to 4 octets long. addr carries the first octet in bits 7:0, the next in 15:8, and so on, with unused octets zero; addr_len gives the count. If none of the first 4 octets ends the address, the frame is rejected.
- R9: A one-octet address is accepted only when its bits 7:1 are 0 (test), 120 to 126 (private group) or 127 (broadcast, octet 0xFF). Any other one-octet address rejects the frame.
- R10: The octet after the address is the MAC control byte, shown on mac_ctrl. If any of its bits 2:0 is 1, the frame is rejected.
- R11: Octets after the control byte, except the last two, appear in order as one-cycle pay_valid pulses, all before the verdict. If a frame has fewer than two octets after the control byte, it is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe marking a valid line sample |
| smp_lvl | input | 1 | Line level sampled at the strobe |
| addr | output | 8*ADDR_MAX | Parsed link address, first octet lowest |
| addr_len | output | clog2(ADDR_MAX+1) | Number of address octets |
| mac_ctrl | output | 8 | MAC control octet |
| pay_valid | output | 1 | Payload octet strobe |
| pay_data | output | 8 | Payload octet |
| frame_ok | output | 1 | Pulse: frame accepted |
| frame_err | output | 1 | Pulse: frame rejected or cancelled |

## Verification
The assertions assume that each strobe carries exactly one line sample, that reset is applied before any traffic, and that the decoder therefore raises at most one of its bit, start, end and cancel events per strobe. The stimulus keeps to these conditions. It issues strobes only on alternate cycles, holds the line high while idle, and builds every frame as preamble, flag, stuffed content and flag, so that frame boundaries never overlap. It places trailing idle ones only after the decoder has gone back to hunting for a preamble.

// File: rtl/ulf_pkg.sv
// Shared constants, state types and the CRC step function for the uplink
// frame receiver. Assumes octets are serialised least significant bit first.
package ulf_pkg;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;  // reflected x^16+x^12+x^5+1
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;  // remainder after data + FCS
    localparam logic [7:0]  FLAG_PAT    = 8'h7E;

    typedef enum logic [1:0] {LN_HUNT, LN_SEEK, LN_FRAME} line_st_t;
    typedef enum logic [1:0] {PF_ADDR, PF_MAC, PF_BODY, PF_DRAIN} parse_st_t;

    // Advances a reflected CRC register by one serial bit.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_step = (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/ulf_line_decoder.sv
// NRZI line decoder with preamble sync, flag/abort detection and destuffing.
// Assumes one sample per strobe and an idle-high line after reset. Emits
// destuffed data bits delayed by the flag length, so the closing flag's
// own bits are never released as data.
module ulf_line_decoder
    import ulf_pkg::*;
#(
    parameter int SYNC_ZEROS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_stb,
    input  logic smp_lvl,
    output logic bit_vld_o,
    output logic bit_o,
    output logic start_o,
    output logic end_o,
    output logic abort_o
);

    localparam int RUN_STUFF = 5;
    localparam int RUN_FLAG  = 6;
    localparam int DLY       = RUN_FLAG;
    localparam int ZW        = $clog2(SYNC_ZEROS + 1);
    localparam int DCW       = $clog2(DLY + 1);

    line_st_t         st_q;
    logic             lvl_q;
    logic [ZW-1:0]    zc_q;
    logic [7:0]       sh_q;
    logic [2:0]       ones_q;
    logic [DLY-1:0]   dl_q;
    logic [DCW-1:0]   dlc_q;

    logic             dec;
    logic             push;
    logic             push_b;

    // Decodes the current sample against the previous line level.
    always_comb dec = (smp_lvl == lvl_q);

    // Decides whether the current in-frame bit is real data.
    always_comb begin
        push   = 1'b0;
        push_b = dec;
        if (smp_stb && st_q == LN_FRAME) begin
            if (dec) push = (ones_q < 3'(RUN_STUFF));
            else     push = (ones_q < 3'(RUN_STUFF));
        end
    end

    // Sequences sync, framing, destuffing and the release delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= LN_HUNT;
            lvl_q     <= 1'b1;
            zc_q      <= '0;
            sh_q      <= '0;
            ones_q    <= '0;
            dl_q      <= '0;
            dlc_q     <= '0;
            bit_vld_o <= 1'b0;
            bit_o     <= 1'b0;
            start_o   <= 1'b0;
            end_o     <= 1'b0;
            abort_o   <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            start_o   <= 1'b0;
            end_o     <= 1'b0;
            abort_o   <= 1'b0;
            if (smp_stb) begin
                lvl_q <= smp_lvl;
                sh_q  <= {sh_q[6:0], dec};
                case (st_q)
                    LN_HUNT: begin
                        if (dec) begin
                            zc_q <= '0;
                        end else if (zc_q == ZW'(SYNC_ZEROS - 1)) begin
                            zc_q   <= '0;
                            ones_q <= '0;
                            st_q   <= LN_SEEK;
                        end else begin
                            zc_q <= zc_q + 1'b1;
                        end
                    end
                    LN_SEEK: begin
                        if ({sh_q[6:0], dec} == FLAG_PAT) begin
                            st_q    <= LN_FRAME;
                            ones_q  <= '0;
                            dlc_q   <= '0;
                            start_o <= 1'b1;
                        end else if (dec && ones_q == 3'(RUN_FLAG)) begin
                            st_q <= LN_HUNT;
                            zc_q <= '0;
                        end else begin
                            ones_q <= dec ? ones_q + 1'b1 : 3'd0;
                        end
                    end
                    LN_FRAME: begin
                        if (dec && ones_q == 3'(RUN_FLAG)) begin
                            abort_o <= 1'b1;
                            st_q    <= LN_HUNT;
                            zc_q    <= '0;
                        end else if (!dec && ones_q == 3'(RUN_FLAG)) begin
                            end_o <= 1'b1;
                            st_q  <= LN_HUNT;
                            zc_q  <= '0;
                        end else begin
                            ones_q <= dec ? ones_q + 1'b1 : 3'd0;
                        end
                        if (push) begin
                            dl_q <= {dl_q[DLY-2:0], push_b};
                            if (dlc_q == DCW'(DLY)) begin
                                bit_vld_o <= 1'b1;
                                bit_o     <= dl_q[DLY-1];
                            end else begin
                                dlc_q <= dlc_q + 1'b1;
                            end
                        end
                    end
                    default: st_q <= LN_HUNT;
                endcase
            end
        end
    end

    // R4 / R2: the decoder raises at most one framing event per cycle.
    a_r4_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_vld_o, start_o, end_o, abort_o}));

    // R3: the release delay line never holds more than a flag's worth of bits.
    a_r3_delay_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dlc_q <= DCW'(DLY));

    // R1: a frame opens only from the flag-search state.
    a_r1_start_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(st_q) == LN_SEEK);

endmodule

// File: rtl/ulf_octet_crc.sv
// Packs destuffed bits into octets (LSB first) and runs the frame CRC.
// Assumes start, bit, end and abort events never coincide. Forwards the
// framing events one cycle later with the length and CRC verdicts.
module ulf_octet_crc
    import ulf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld_i,
    input  logic       bit_i,
    input  logic       start_i,
    input  logic       end_i,
    input  logic       abort_i,
    output logic       oct_vld_o,
    output logic [7:0] oct_o,
    output logic       start_o,
    output logic       end_o,
    output logic       abort_o,
    output logic       partial_o,
    output logic       crc_good_o
);

    logic [7:0]  sreg_q;
    logic [2:0]  bcnt_q;
    logic [15:0] crc_q;

    // Assembles octets, updates the CRC and forwards framing events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q     <= '0;
            bcnt_q     <= '0;
            crc_q      <= CRC_PRESET;
            oct_vld_o  <= 1'b0;
            oct_o      <= '0;
            start_o    <= 1'b0;
            end_o      <= 1'b0;
            abort_o    <= 1'b0;
            partial_o  <= 1'b0;
            crc_good_o <= 1'b0;
        end else begin
            oct_vld_o <= 1'b0;
            start_o   <= start_i;
            end_o     <= end_i;
            abort_o   <= abort_i;
            if (start_i) begin
                crc_q  <= CRC_PRESET;
                bcnt_q <= '0;
            end else if (bit_vld_i) begin
                sreg_q <= {bit_i, sreg_q[7:1]};
                bcnt_q <= bcnt_q + 1'b1;
                crc_q  <= crc_step(crc_q, bit_i);
                if (bcnt_q == 3'd7) begin
                    oct_vld_o <= 1'b1;
                    oct_o     <= {bit_i, sreg_q[7:1]};
                end
            end
            if (end_i) begin
                partial_o  <= (bcnt_q != 3'd0);
                crc_good_o <= (crc_q == CRC_RESIDUE);
            end
        end
    end

    // R5: an octet is only released in the cycle after a data bit.
    a_r5_octet_from_bit: assert property (@(posedge clk) disable iff (!rst_n)
        oct_vld_o |-> $past(bit_vld_i));

    // R7: the verdict flags only change alongside an end event.
    a_r7_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !end_o |-> $stable(crc_good_o));

endmodule

// File: rtl/uplink_deframer.sv
// Uplink frame receiver top: line decoding, octet/CRC stage and the
// link-layer parser. Assumes reset precedes traffic. Streams payload while
// holding back the two check octets, then issues one verdict pulse.
module uplink_deframer
    import ulf_pkg::*;
#(
    parameter int MAX_OCT    = 64,
    parameter int ADDR_MAX   = 4,
    parameter int SYNC_ZEROS = 8,
    parameter int GRP_LO     = 120
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_stb,
    input  logic                          smp_lvl,
    output logic [8*ADDR_MAX-1:0]         addr,
    output logic [$clog2(ADDR_MAX+1)-1:0] addr_len,
    output logic [7:0]                    mac_ctrl,
    output logic                          pay_valid,
    output logic [7:0]                    pay_data,
    output logic                          frame_ok,
    output logic                          frame_err
);

    localparam int OCW = $clog2(MAX_OCT + 2);
    localparam int ALW = $clog2(ADDR_MAX + 1);
    localparam int FCS_OCT = 2;

    logic       d_bit_vld, d_bit, d_start, d_end, d_abort;
    logic       o_vld, o_start, o_end, o_abort, o_partial, o_crc_good;
    logic [7:0] o_oct;

    ulf_line_decoder #(.SYNC_ZEROS(SYNC_ZEROS)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .smp_lvl   (smp_lvl),
        .bit_vld_o (d_bit_vld),
        .bit_o     (d_bit),
        .start_o   (d_start),
        .end_o     (d_end),
        .abort_o   (d_abort)
    );

    ulf_octet_crc u_oct (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (d_bit_vld),
        .bit_i      (d_bit),
        .start_i    (d_start),
        .end_i      (d_end),
        .abort_i    (d_abort),
        .oct_vld_o  (o_vld),
        .oct_o      (o_oct),
        .start_o    (o_start),
        .end_o      (o_end),
        .abort_o    (o_abort),
        .partial_o  (o_partial),
        .crc_good_o (o_crc_good)
    );

    parse_st_t  pst_q;
    logic [OCW-1:0] ocnt_q;
    logic       over_q;
    logic       bad_q;
    logic [7:0] hold0_q, hold1_q;
    logic [1:0] body_q;
    logic       one_oct_ok;

    // Classifies a terminating first address octet by its upper seven bits.
    always_comb one_oct_ok = (o_oct[7:1] == 7'd0) || (o_oct[7:1] >= 7'(GRP_LO));

    // Parses address, control and body octets and issues the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q     <= PF_ADDR;
            ocnt_q    <= '0;
            over_q    <= 1'b0;
            bad_q     <= 1'b0;
            hold0_q   <= '0;
            hold1_q   <= '0;
            body_q    <= '0;
            addr      <= '0;
            addr_len  <= '0;
            mac_ctrl  <= '0;
            pay_valid <= 1'b0;
            pay_data  <= '0;
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            pay_valid <= 1'b0;
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
            if (o_start) begin
                pst_q    <= PF_ADDR;
                ocnt_q   <= '0;
                over_q   <= 1'b0;
                bad_q    <= 1'b0;
                body_q   <= '0;
                addr     <= '0;
                addr_len <= '0;
                mac_ctrl <= '0;
            end else if (o_vld) begin
                if (ocnt_q == OCW'(MAX_OCT)) over_q <= 1'b1;
                else                         ocnt_q <= ocnt_q + 1'b1;
                case (pst_q)
                    PF_ADDR: begin
                        for (int i = 0; i < ADDR_MAX; i++) begin
                            if (addr_len == ALW'(i)) addr[8*i +: 8] <= o_oct;
                        end
                        addr_len <= addr_len + 1'b1;
                        if (o_oct[0]) begin
                            if (addr_len == '0 && !one_oct_ok) bad_q <= 1'b1;
                            pst_q <= PF_MAC;
                        end else if (addr_len == ALW'(ADDR_MAX - 1)) begin
                            bad_q <= 1'b1;
                            pst_q <= PF_DRAIN;
                        end
                    end
                    PF_MAC: begin
                        mac_ctrl <= o_oct;
                        if (o_oct[2:0] != 3'd0) bad_q <= 1'b1;
                        pst_q <= PF_BODY;
                    end
                    PF_BODY: begin
                        hold0_q <= o_oct;
                        hold1_q <= hold0_q;
                        if (body_q == 2'(FCS_OCT)) begin
                            if (!over_q) begin
                                pay_valid <= 1'b1;
                                pay_data  <= hold1_q;
                            end
                        end else begin
                            body_q <= body_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (o_end) begin
                if (!bad_q && !over_q && !o_partial && o_crc_good &&
                    pst_q == PF_BODY && body_q == 2'(FCS_OCT))
                    frame_ok <= 1'b1;
                else
                    frame_err <= 1'b1;
            end
            if (o_abort) frame_err <= 1'b1;
        end
    end

    // R2 / R11: never both verdicts in one cycle.
    a_r11_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_ok, frame_err}));

    // R11: payload octets never share a cycle with a verdict.
    a_r11_payload_before_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> !(frame_ok || frame_err));

    // R8: the address count never passes its limit.
    a_r8_addr_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        addr_len <= ALW'(ADDR_MAX));

    // R10: an accepted frame always carries clear reserved control bits.
    a_r10_mac_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> mac_ctrl[2:0] == 3'd0);

    // R9: an accepted one-octet address is test, group or broadcast.
    a_r9_single_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && addr_len == ALW'(1)) |->
            (addr[7:1] == 7'd0 || addr[7:1] >= 7'(GRP_LO)));

endmodule

// File: tb/uplink_deframer_test.sv
module uplink_deframer_test;

    localparam int TB_MAX = 16;
    localparam int AM     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic smp_lvl = 1'b1;
    logic [8*AM-1:0] addr;
    logic [2:0]      addr_len;
    logic [7:0]      mac_ctrl;
    logic            pay_valid;
    logic [7:0]      pay_data;
    logic            frame_ok;
    logic            frame_err;

    always #10 clk = ~clk;

    uplink_deframer #(.MAX_OCT(TB_MAX), .ADDR_MAX(AM)) uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_lvl(smp_lvl),
        .addr(addr), .addr_len(addr_len), .mac_ctrl(mac_ctrl),
        .pay_valid(pay_valid), .pay_data(pay_data),
        .frame_ok(frame_ok), .frame_err(frame_err)
    );

    int checks = 0;
    int errors = 0;
    int n_ok = 0;
    int n_err = 0;
    byte unsigned got[$];
    byte unsigned cont[$];
    bit  line_q[$];
    bit  lvl = 1'b1;
    int  ones_run = 0;
    bit  m_crc_bad, m_extra, m_nopre, m_abort;

    // Collects outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_valid) got.push_back(pay_data);
            if (frame_ok)  n_ok++;
            if (frame_err) n_err++;
        end
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic raw(input bit b);
        line_q.push_back(b);
    endtask

    task automatic stuffed(input bit b);
        line_q.push_back(b);
        if (b) ones_run++; else ones_run = 0;
        if (ones_run == 5) begin
            line_q.push_back(1'b0);
            ones_run = 0;
        end
    endtask

    task automatic raw_flag();
        raw(0); for (int i = 0; i < 6; i++) raw(1); raw(0);
    endtask

    task automatic stuffed_byte(input byte unsigned v);
        for (int i = 0; i < 8; i++) stuffed(v[i]);
    endtask

    function automatic logic [15:0] calc_fcs();
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < cont.size(); k++)
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ cont[k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return ~c;
    endfunction

    // Builds the decoded bit sequence for the current frame and modes.
    task automatic build();
        logic [15:0] f;
        line_q.delete();
        ones_run = 0;
        for (int i = 0; i < 3; i++) raw(1);
        if (m_nopre) for (int i = 0; i < 4; i++) raw(0);
        else         for (int i = 0; i < 8; i++) raw(0);
        raw_flag();
        ones_run = 0;
        foreach (cont[k]) stuffed_byte(cont[k]);
        if (m_abort) begin
            for (int i = 0; i < 7; i++) raw(1);
        end else begin
            if (!m_nopre) begin
                f = calc_fcs();
                if (m_crc_bad) f = f ^ 16'h0100;
                stuffed_byte(f[7:0]);
                stuffed_byte(f[15:8]);
            end
            if (m_extra) begin stuffed(1); stuffed(0); stuffed(1); end
            raw_flag();
        end
        for (int i = 0; i < 10; i++) raw(1);
    endtask

    // NRZI-encodes and drives the line, one strobe every other cycle.
    task automatic drive();
        foreach (line_q[k]) begin
            @(negedge clk);
            if (!line_q[k]) lvl = ~lvl;
            smp_lvl = lvl;
            smp_stb = 1'b1;
            @(negedge clk);
            smp_stb = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    // Expected verdict: 0 accept, 1 reject, 2 nothing.
    function automatic int exp_code(output int alen);
        int u;
        alen = 0;
        if (m_nopre) return 2;
        if (m_abort || m_crc_bad || m_extra) return 1;
        if (cont.size() + 2 > TB_MAX) return 1;
        for (int i = 0; i < AM && i < cont.size(); i++)
            if (cont[i][0]) begin alen = i + 1; break; end
        if (alen == 0) return 1;
        if (alen == 1) begin
            u = cont[0] >> 1;
            if (!(u == 0 || u >= 120)) return 1;
        end
        if (cont.size() < alen + 1) return 1;
        if ((cont[alen] & 8'h07) != 0) return 1;
        return 0;
    endfunction

    task automatic run(input string req);
        int alen, e;
        logic [8*AM-1:0] ea;
        got.delete(); n_ok = 0; n_err = 0;
        build();
        drive();
        e = exp_code(alen);
        chk(n_ok == (e == 0 ? 1 : 0) && n_err == (e == 1 ? 1 : 0), req,
            n_ok * 10 + n_err, (e == 0) ? 10 : (e == 1 ? 1 : 0));
        if (e == 0) begin
            int np = cont.size() - alen - 1;
            bit same = (got.size() == np);
            if (same) for (int i = 0; i < np; i++)
                if (got[i] != cont[alen + 1 + i]) same = 0;
            chk(same, {req, " R11 payload"}, got.size(), np);
            ea = '0;
            for (int i = 0; i < alen; i++) ea[8*i +: 8] = cont[i];
            chk(addr == ea && addr_len == 3'(alen), {req, " R8 address"},
                int'(addr_len), alen);
            chk(mac_ctrl == cont[alen], {req, " R10 control"},
                int'(mac_ctrl), int'(cont[alen]));
        end else begin
            chk(got.size() == 0 || e == 1, {req, " R11 no payload"}, got.size(), 0);
        end
        m_crc_bad = 0; m_extra = 0; m_nopre = 0; m_abort = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_crc_bad = 0; m_extra = 0; m_nopre = 0; m_abort = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!frame_ok && !frame_err && !pay_valid && addr_len == 0 && addr == 0,
            "R2 reset state", int'(frame_ok) + int'(frame_err), 0);

        // R9: every one-octet address.
        for (int u = 0; u < 128; u++) begin
            cont.delete();
            cont.push_back(byte'((u << 1) | 1)); cont.push_back(8'h10); cont.push_back(8'hA5);
            run("R9 single-octet address");
        end

        // R10: every reserved-bit pattern.
        for (int m = 0; m < 8; m++) begin
            cont.delete();
            cont.push_back(8'hFF); cont.push_back(byte'(8'h48 | m)); cont.push_back(8'h3C);
            run("R10 control reserved bits");
        end

        // R6 / R11: payload lengths around the octet limit.
        for (int n = 0; n < 15; n++) begin
            cont.delete();
            cont.push_back(8'h01); cont.push_back(8'h20);
            for (int k = 0; k < n; k++) cont.push_back(byte'((k * 37 + 8'hF3) & 8'hFF));
            run("R6 length sweep");
        end

        // R8: address lengths 2 to 5.
        for (int a = 2; a <= 5; a++) begin
            cont.delete();
            for (int k = 0; k < a - 1; k++) cont.push_back(byte'(2 * k + 2));
            cont.push_back(8'h09); cont.push_back(8'h30); cont.push_back(8'h77);
            run("R8 address length");
        end

        // R3: ones-heavy payload needing stuffing.
        cont.delete();
        cont.push_back(8'hFF); cont.push_back(8'hF8);
        cont.push_back(8'hFF); cont.push_back(8'h7E); cont.push_back(8'h3F); cont.push_back(8'hFC);
        run("R3 destuffing");

        // R7: damaged check field.
        cont.delete();
        cont.push_back(8'hF1); cont.push_back(8'h08); cont.push_back(8'h55);
        m_crc_bad = 1;
        run("R7 crc mismatch");

        // R5: three extra bits before the closing flag.
        cont.delete();
        cont.push_back(8'hF1); cont.push_back(8'h08); cont.push_back(8'h55);
        m_extra = 1;
        run("R5 partial octet");

        // R4: seven ones inside a frame.
        cont.delete();
        cont.push_back(8'h01); cont.push_back(8'h08);
        m_abort = 1;
        run("R4 abort");

        // R1: flag without the sync run is ignored, then recovery.
        cont.delete();
        cont.push_back(8'hA5); cont.push_back(8'hA5);
        m_nopre = 1;
        run("R1 no preamble");
        cont.delete();
        cont.push_back(8'hFF); cont.push_back(8'h00); cont.push_back(8'h5A);
        run("R1 R2 recovery frame");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule